// File: doc/BRIEF.md
# Bus Phase Strobe Qualifier

This block sits at the cartridge edge of a retro CPU bus and conditions the CPU phase clock with a fast local clock. The phase clock rises some tens of nanoseconds before the active-low ROM select settles low. A decoder that uses the raw phase clock therefore sees a short window in which an access to the top 8 KiB of the address space looks like an access to the work-RAM window, and it can corrupt that RAM.

The block passes the raw bus signals through a multi-flop synchronizer. It then makes a qualified phase clock whose rising edge is held back by a programmable number of fast-clock samples. Its falling edge follows the synchronized input with no added delay. The top address bit is rebuilt from the ROM select line. Two chip enables are gated by the qualified phase: the work-RAM window at $6000-$7FFF and the expansion window at $4000-$5FFF. A one-cycle write strobe marks the falling phase edge of each write, when data and address are stable.

Top module: `bus_phase_qualifier`

## Requirements
- R1: While reset is held, phi_dly_o and wr_stb_o are 0, wram_ce_n_o and exp_ce_n_o are 1, and a15_o is 0 when rom_sel_n_i is 1.
- R2: phi_dly_o rises only after the synchronized phase clock has been high for RISE_DLY consecutive samples. With default parameters and a rise driven between clock edges, phi_dly_o is still 0 after the 6th following rising edge and is 1 after the 7th.
- R3: phi_dly_o falls in the same cycle as the synchronized phase clock falls. This is 2 rising edges after the raw phase clock falls.
- R4: A phase-high interval shorter than the delay never produces phi_dly_o. A low sample partway through a count restarts the count from zero.
- R5: a15_o is the inverse of rom_sel_n_i seen through the synchronizer, with a latency of 2 rising edges.
- R6: wram_ce_n_o (active low) is 0 exactly when phi_dly_o is 1, a15_o is 0, a14_i is 1 and a13_i is 1.
- R7: exp_ce_n_o (active low) is 0 exactly when phi_dly_o is 1, a15_o is 0, a14_i is 1 and a13_i is 0. The two enables are never low together.
- R8: If rom_sel_n_i falls during the delay window after the phase rise, neither enable asserts at any point during that phase. This covers an access to the top address range whose select lags the phase clock.
- R9: When rd_wr_n_i is 0 (write), wr_stb_o pulses high for exactly one cycle, 3 rising edges after the raw phase clock falls. On reads (rd_wr_n_i = 1) it stays 0.
- R10: wr_stb_o never pulses on a rising phase edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| phi_raw_i | input | 1 | Raw CPU phase clock from the bus |
| rom_sel_n_i | input | 1 | Active-low ROM select from the bus |
| a14_i | input | 1 | CPU address bit 14 |
| a13_i | input | 1 | CPU address bit 13 |
| rd_wr_n_i | input | 1 | CPU direction, 1 = read, 0 = write |
| phi_dly_o | output | 1 | Qualified phase clock, rise delayed, fall prompt |
| a15_o | output | 1 | Rebuilt address bit 15 |
| wram_ce_n_o | output | 1 | Work-RAM window enable, active low |
| exp_ce_n_o | output | 1 | Expansion window enable, active low |
| wr_stb_o | output | 1 | One-cycle write latch strobe |

## Verification
Some properties are checked on every cycle. The qualified phase never rises before the synchronized phase has been high for the full count. It is never high while the synchronized phase is low. Neither enable is low without the qualified phase and a low top address bit, and the two enables are never low together. The strobe is one cycle wide and follows a falling phase edge. Only the directed scenarios can show the exact edge counts: the rise latency, the prompt fall, the latency of the rebuilt address bit and the strobe position. They also cover the restart of an interrupted count and the masking of a late ROM select during a real access.

// File: rtl/bpq_pkg.sv
// Shared types for the bus phase qualifier.
// Assumes the synchronized bus is carried as one packed word.
package bpq_pkg;
    localparam int unsigned BUS_W = 5;

    typedef struct packed {
        logic phi;     // phase clock
        logic rsel_n;  // ROM select, active low
        logic a14;
        logic a13;
        logic rd_n;    // 1 = read, 0 = write
    } bus_s_t;

    localparam bus_s_t BUS_IDLE = '{phi: 1'b0, rsel_n: 1'b1, a14: 1'b0, a13: 1'b0, rd_n: 1'b1};
endpackage

// File: rtl/bpq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2. Each bit resets to its own value from RST_VAL.
module bpq_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // shift the raw bit through the flop chain
        always_ff @(posedge clk_i) begin
            if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
            else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end

        assign q_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/bpq_rise_qual.sv
// Asymmetric delay of the synchronized phase clock.
// The rising edge waits for DLY consecutive high samples. The falling
// edge follows the input in the same cycle. DLY = 0 passes the input through.
module bpq_rise_qual #(
    parameter int unsigned DLY = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phi_i,
    output logic phi_dly_o
);
    if (DLY == 0) begin : g_pass
        assign phi_dly_o = phi_i;
    end else begin : g_count
        localparam int unsigned CW = $clog2(DLY + 1);
        logic [CW-1:0] cnt_q;
        logic          armed_q;

        // count consecutive high samples, restart on any low sample
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (!phi_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (!armed_q) begin
                if (cnt_q == CW'(DLY - 1)) armed_q <= 1'b1;
                else                       cnt_q   <= cnt_q + CW'(1);
            end
        end

        // gate with the live input so the fall adds no cycle
        assign phi_dly_o = phi_i & armed_q;
    end
endmodule

// File: rtl/bpq_decode.sv
// Rebuilds A15 and decodes the two low-memory windows. Also makes
// the write latch strobe.
// Assumes all bus inputs are already synchronized to clk_i.
module bpq_decode
    import bpq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  bus_s_t bus_i,
    input  logic   phi_dly_i,
    output logic   a15_o,
    output logic   wram_ce_n_o,
    output logic   exp_ce_n_o,
    output logic   wr_stb_o
);
    logic phi_prev_q;
    logic stb_q;
    logic low_half;

    // ROM select low means the CPU addresses the upper half
    assign a15_o    = ~bus_i.rsel_n;
    assign low_half = phi_dly_i & ~a15_o & bus_i.a14;

    // window enables, both gated by the qualified phase
    always_comb begin
        wram_ce_n_o = ~(low_half &  bus_i.a13);
        exp_ce_n_o  = ~(low_half & ~bus_i.a13);
    end

    // remember last phase sample and flag a falling edge on writes
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phi_prev_q <= 1'b0;
            stb_q      <= 1'b0;
        end else begin
            phi_prev_q <= bus_i.phi;
            stb_q      <= phi_prev_q & ~bus_i.phi & ~bus_i.rd_n;
        end
    end

    assign wr_stb_o = stb_q;
endmodule

// File: rtl/bus_phase_qualifier.sv
// Top of the bus phase qualifier. Synchronizes the raw bus, delays
// the rising phase edge and decodes the low-memory windows.
// Assumes clk_i is fast enough that RISE_DLY periods cover the ROM
// select lag, and that inputs are asynchronous to clk_i.
module bus_phase_qualifier
    import bpq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RISE_DLY    = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phi_raw_i,
    input  logic rom_sel_n_i,
    input  logic a14_i,
    input  logic a13_i,
    input  logic rd_wr_n_i,
    output logic phi_dly_o,
    output logic a15_o,
    output logic wram_ce_n_o,
    output logic exp_ce_n_o,
    output logic wr_stb_o
);
    logic [BUS_W-1:0] raw_v;
    logic [BUS_W-1:0] sync_v;
    bus_s_t           bus_s;
    logic             phi_sync;

    // pack raw pins in struct order
    assign raw_v    = {phi_raw_i, rom_sel_n_i, a14_i, a13_i, rd_wr_n_i};
    assign bus_s    = bus_s_t'(sync_v);
    assign phi_sync = bus_s.phi;

    bpq_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_v),
        .q_o    (sync_v)
    );

    bpq_rise_qual #(
        .DLY (RISE_DLY)
    ) u_rise (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .phi_i     (phi_sync),
        .phi_dly_o (phi_dly_o)
    );

    bpq_decode u_dec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_i       (bus_s),
        .phi_dly_i   (phi_dly_o),
        .a15_o       (a15_o),
        .wram_ce_n_o (wram_ce_n_o),
        .exp_ce_n_o  (exp_ce_n_o),
        .wr_stb_o    (wr_stb_o)
    );
endmodule

// File: rtl/bpq_checker.sv
// Cycle properties of the bus phase qualifier. Bound to the top.
// Assumes the synchronized phase clock is brought in from the top.
module bpq_checker #(
    parameter int unsigned DLY = 5
) (
    input logic clk_i,
    input logic rst_ni,
    input logic phi_sync_i,
    input logic phi_dly_i,
    input logic a15_i,
    input logic wram_ce_n_i,
    input logic exp_ce_n_i,
    input logic wr_stb_i
);
    localparam int unsigned RW = $clog2(DLY + 2);
    logic [RW-1:0] run_q;

    // saturating run length of high synchronized phase samples
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                run_q <= '0;
        else if (!phi_sync_i)       run_q <= '0;
        else if (run_q < RW'(DLY))  run_q <= run_q + RW'(1);
    end

    AST_RISE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phi_dly_i) |-> (run_q >= RW'(DLY))); // R2
    AST_FALL_PROMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phi_sync_i |-> !phi_dly_i); // R3
    AST_WRAM_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wram_ce_n_i |-> (phi_dly_i && !a15_i)); // R6
    AST_EXP_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exp_ce_n_i |-> (phi_dly_i && !a15_i)); // R7
    AST_CE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wram_ce_n_i || exp_ce_n_i)); // R7
    AST_UPPER_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a15_i |-> (wram_ce_n_i && exp_ce_n_i)); // R8
    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_i |=> !wr_stb_i); // R9
    AST_STB_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_i |-> (!$past(phi_sync_i) && $past(phi_sync_i, 2))); // R10
endmodule

bind bus_phase_qualifier bpq_checker #(
    .DLY (RISE_DLY)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phi_sync_i  (phi_sync),
    .phi_dly_i   (phi_dly_o),
    .a15_i       (a15_o),
    .wram_ce_n_i (wram_ce_n_o),
    .exp_ce_n_i  (exp_ce_n_o),
    .wr_stb_i    (wr_stb_o)
);

// File: tb/bus_phase_qualifier_bench.sv
// Directed bench: one task per scenario, inputs driven on falling edges.
module bus_phase_qualifier_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, phi, rsel_n, a14, a13, rdn;
    logic phi_dly, a15, wram_ce_n, exp_ce_n, wr_stb;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    bus_phase_qualifier u_bus_phase_qualifier (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .phi_raw_i   (phi),
        .rom_sel_n_i (rsel_n),
        .a14_i       (a14),
        .a13_i       (a13),
        .rd_wr_n_i   (rdn),
        .phi_dly_o   (phi_dly),
        .a15_o       (a15),
        .wram_ce_n_o (wram_ce_n),
        .exp_ce_n_o  (exp_ce_n),
        .wr_stb_o    (wr_stb)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle();
        phi = 1'b0; rsel_n = 1'b1; a14 = 1'b0; a13 = 1'b0; rdn = 1'b1;
        adv(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        phi = 1'b1; rsel_n = 1'b1; a14 = 1'b1; a13 = 1'b1; rdn = 1'b0;
        adv(3);
        chk("R1 phi_dly", phi_dly, 1'b0);
        chk("R1 wram_ce_n", wram_ce_n, 1'b1);
        chk("R1 exp_ce_n", exp_ce_n, 1'b1);
        chk("R1 wr_stb", wr_stb, 1'b0);
        chk("R1 a15", a15, 1'b0);
        phi = 1'b0; a14 = 1'b0; a13 = 1'b0; rdn = 1'b1;
        adv(1);
        rst_n = 1'b1;
        adv(3);
    endtask

    task automatic t_rise_fall();
        phi = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            adv(1);
            chk("R2 early", phi_dly, 1'b0);
            chk("R10 no strobe on rise", wr_stb, 1'b0);
        end
        adv(1);
        chk("R2 qualified", phi_dly, 1'b1);
        adv(3);
        phi = 1'b0;
        adv(1);
        chk("R3 still high", phi_dly, 1'b1);
        adv(1);
        chk("R3 fallen", phi_dly, 1'b0);
        for (int k = 0; k < 3; k++) begin
            adv(1);
            chk("R9 no strobe on read", wr_stb, 1'b0);
        end
        idle();
    endtask

    task automatic t_short_and_restart();
        phi = 1'b1;
        adv(4);
        phi = 1'b0;
        for (int k = 0; k < 8; k++) begin
            adv(1);
            chk("R4 short pulse", phi_dly, 1'b0);
        end
        phi = 1'b1;
        adv(3);
        phi = 1'b0;
        adv(1);
        phi = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            adv(1);
            chk("R4 restart count", phi_dly, 1'b0);
        end
        adv(1);
        chk("R4 qualified after restart", phi_dly, 1'b1);
        idle();
    endtask

    task automatic t_a15();
        rsel_n = 1'b0;
        adv(1);
        chk("R5 a15 latency", a15, 1'b0);
        adv(1);
        chk("R5 a15 set", a15, 1'b1);
        rsel_n = 1'b1;
        adv(2);
        chk("R5 a15 clear", a15, 1'b0);
        idle();
    endtask

    task automatic t_wram_write();
        a14 = 1'b1; a13 = 1'b1; rdn = 1'b0; phi = 1'b1;
        adv(6);
        chk("R6 wram before qualify", wram_ce_n, 1'b1);
        adv(1);
        chk("R6 wram enabled", wram_ce_n, 1'b0);
        chk("R7 exp off in wram", exp_ce_n, 1'b1);
        adv(2);
        phi = 1'b0;
        adv(2);
        chk("R6 wram off after fall", wram_ce_n, 1'b1);
        chk("R9 strobe not yet", wr_stb, 1'b0);
        adv(1);
        chk("R9 strobe pulse", wr_stb, 1'b1);
        adv(1);
        chk("R9 strobe one cycle", wr_stb, 1'b0);
        idle();
    endtask

    task automatic t_exp();
        a14 = 1'b1; a13 = 1'b0; phi = 1'b1;
        adv(7);
        chk("R7 exp enabled", exp_ce_n, 1'b0);
        chk("R6 wram off in exp", wram_ce_n, 1'b1);
        idle();
        a14 = 1'b0; a13 = 1'b1; phi = 1'b1;
        adv(8);
        chk("R6 no wram at A14=0", wram_ce_n, 1'b1);
        chk("R7 no exp at A14=0", exp_ce_n, 1'b1);
        chk("R2 phi_dly in other window", phi_dly, 1'b1);
        idle();
    endtask

    task automatic t_upper_masked();
        a14 = 1'b1; a13 = 1'b1; rdn = 1'b0; phi = 1'b1;
        for (int k = 0; k < 4; k++) begin
            adv(1);
            chk("R8 wram before select", wram_ce_n, 1'b1);
        end
        rsel_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            adv(1);
            chk("R8 wram masked", wram_ce_n, 1'b1);
            chk("R8 exp masked", exp_ce_n, 1'b1);
        end
        chk("R8 phase qualified", phi_dly, 1'b1);
        chk("R5 a15 in upper access", a15, 1'b1);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rise_fall();
        t_short_and_restart();
        t_a15();
        t_wram_write();
        t_exp();
        t_upper_masked();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule